// File: doc/BRIEF.md
# Strobed Charger Status Multiplexer and Control Demultiplexer

This block links a host controller to six charger channels through one shared channel select and one strobe line. When the strobe rises, the block reads the 3-bit status group of the selected channel from a wide status bus and holds it on a narrow status output. When the strobe falls, the block writes a 2-bit control word into the selected channel's slot of a wide control bus. All other slots keep their values.

The strobe is asynchronous to the block clock. It passes through a two-flop synchronizer, and its edges are found by comparing the synchronized level with its value one cycle earlier. The host must hold the select, status bus and control word stable while an edge travels through the synchronizer. Only select codes 0 to 5 name a channel. Codes 6 and 7 cause neither a read nor a write.

Top module: `chg_link`

## Requirements
- R1: After reset, `stat_o` is 0 and every bit of `ctrl_bus_o` is 0.
- R2: On a rising strobe edge with select n (0 to 5), `stat_o` takes the value of `stat_bus_i[3n+2:3n]`.
- R3: On a falling strobe edge with select n (0 to 5), `ctrl_bus_o[2n+1:2n]` takes the value of `ctrl_word_i`.
- R4: A falling strobe edge changes only the selected 2-bit group of `ctrl_bus_o`. Every other group keeps its value.
- R5: A rising strobe edge with select 6 or 7 leaves `stat_o` unchanged.
- R6: A falling strobe edge with select 6 or 7 leaves all of `ctrl_bus_o` unchanged.
- R7: `stat_o` changes only on a rising strobe edge. It does not follow `stat_bus_i` between edges, and a falling edge does not change it.
- R8: An output responds on the third rising clock edge after the strobe changes: two synchronizer stages, then the output register. It does not respond on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Asynchronous strobe. A rise reads status and a fall writes control |
| sel_i | input | 3 | Channel select. Codes 0 to 5 are valid |
| stat_bus_i | input | 18 | Status of six channels, 3 bits each, with channel n at bits 3n+2:3n |
| stat_o | output | 3 | Captured status of the selected channel |
| ctrl_word_i | input | 2 | Control word to write |
| ctrl_bus_o | output | 12 | Control of six channels, 2 bits each, with channel n at bits 2n+1:2n |

## Verification
Three situations are hard to reach from the ports.

- **Holding between edges (R7):** the status output must ignore the status bus between strobe edges. The bench changes `stat_bus_i` while the strobe is steady, and again around a falling edge, then confirms that `stat_o` still holds the value captured earlier.
- **Invalid select codes (R5, R6):** a strobe edge with select 6 or 7 must do nothing. The bench first loads known, distinct values into the status output and into every control group. It then sends both edge types with a select of 6 or 7 and checks that every output is unchanged.
- **Edge latency (R8):** the bench changes the strobe just after a falling clock edge. It samples the outputs once after two rising clock edges, where they must not have moved, and once after three, where they must.

// File: rtl/chg_pkg.sv
package chg_pkg;
  localparam int NUM_CH  = 6;
  localparam int STAT_W  = 3;
  localparam int CTRL_W  = 2;
  localparam int SEL_W   = $clog2(NUM_CH);
  localparam int SYNC_N  = 2;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;

  // R8: a rise and a fall cannot be reported together, and each lasts one cycle
  assert_edge_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  assert_rise_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/status_capture.sv
module status_capture #(
  parameter int NUM_CH = 6,
  parameter int GRP_W  = 3,
  parameter int SEL_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rise_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [NUM_CH*GRP_W-1:0] bus_i,
  output logic [GRP_W-1:0]        stat_o
);
  logic             sel_ok;
  logic [GRP_W-1:0] grp_pick;

  assign sel_ok   = int'(sel_i) < NUM_CH;
  assign grp_pick = sel_ok ? bus_i[int'(sel_i)*GRP_W +: GRP_W] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               stat_o <= '0;
    else if (rise_i && sel_ok) stat_o <= grp_pick;
  end

  assert_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && int'(sel_i) < NUM_CH) |=> stat_o == $past(bus_i[int'(sel_i)*GRP_W +: GRP_W]));
  assert_bad_sel_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && int'(sel_i) >= NUM_CH) |=> $stable(stat_o));
  assert_hold_between_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_i |=> $stable(stat_o));
endmodule

// File: rtl/ctrl_bank.sv
module ctrl_bank #(
  parameter int NUM_CH = 6,
  parameter int GRP_W  = 2,
  parameter int SEL_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fall_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [GRP_W-1:0]        word_i,
  output logic [NUM_CH*GRP_W-1:0] bus_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic [GRP_W-1:0] grp_q;
    logic             hit;

    assign hit = fall_i && (sel_i == SEL_W'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  grp_q <= '0;
      else if (hit) grp_q <= word_i;
    end

    assign bus_o[n*GRP_W +: GRP_W] = grp_q;

    assert_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fall_i && int'(sel_i) == n) |=> bus_o[n*GRP_W +: GRP_W] == $past(word_i));
    assert_other_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int'(sel_i) != n) |=> $stable(bus_o[n*GRP_W +: GRP_W]));
  end

  assert_bad_sel_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && int'(sel_i) >= NUM_CH) |=> $stable(bus_o));
  assert_no_fall_keep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall_i |=> $stable(bus_o));
endmodule

// File: rtl/chg_link.sv
module chg_link
  import chg_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [NUM_CH*STAT_W-1:0] stat_bus_i,
  output logic [STAT_W-1:0]        stat_o,
  input  logic [CTRL_W-1:0]        ctrl_word_i,
  output logic [NUM_CH*CTRL_W-1:0] ctrl_bus_o
);
  logic rise, fall;

  strobe_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  status_capture #(.NUM_CH(NUM_CH), .GRP_W(STAT_W), .SEL_W(SEL_W)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .sel_i  (sel_i),
    .bus_i  (stat_bus_i),
    .stat_o (stat_o)
  );

  ctrl_bank #(.NUM_CH(NUM_CH), .GRP_W(CTRL_W), .SEL_W(SEL_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fall_i (fall),
    .sel_i  (sel_i),
    .word_i (ctrl_word_i),
    .bus_o  (ctrl_bus_o)
  );

  // R7: a falling strobe edge never moves the status output
  assert_fall_no_stat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall |=> $stable(stat_o));
endmodule

// File: tb/sim_chg_link.sv
module sim_chg_link;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strobe_i = 1'b0;
  logic [2:0]  sel_i = '0;
  logic [17:0] stat_bus_i = '0;
  logic [2:0]  stat_o;
  logic [1:0]  ctrl_word_i = '0;
  logic [11:0] ctrl_bus_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [2:0]  exp_stat = '0;
  logic [11:0] exp_ctrl = '0;

  always #2.5 clk_i = ~clk_i;

  chg_link u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe_i),
    .sel_i       (sel_i),
    .stat_bus_i  (stat_bus_i),
    .stat_o      (stat_o),
    .ctrl_word_i (ctrl_word_i),
    .ctrl_bus_o  (ctrl_bus_o)
  );

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive strobe level, update bench model, wait for the result to settle
  task automatic strobe_to(input logic v);
    @(negedge clk_i);
    if (v && !strobe_i && sel_i < 6) exp_stat = stat_bus_i[sel_i*3 +: 3];
    if (!v && strobe_i && sel_i < 6) exp_ctrl[sel_i*2 +: 2] = ctrl_word_i;
    strobe_i = v;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R1 stat", {9'b0, stat_o}, 12'h000);
    chk("R1 ctrl", ctrl_bus_o, 12'h000);
  endtask

  task automatic t_read;
    stat_bus_i = 18'b101_011_110_001_111_010;
    for (int n = 0; n < 6; n++) begin
      sel_i = 3'(n);
      ctrl_word_i = 2'(n + 1);
      strobe_to(1'b1);
      chk($sformatf("R2 ch%0d", n), {9'b0, stat_o}, {9'b0, exp_stat});
      strobe_to(1'b0);
    end
  endtask

  task automatic t_write;
    logic [1:0] w;
    for (int n = 0; n < 6; n++) begin
      w = 2'(3 - (n % 4));
      sel_i = 3'(n);
      ctrl_word_i = w;
      strobe_to(1'b1);
      strobe_to(1'b0);
      chk($sformatf("R3 ch%0d", n), {10'b0, ctrl_bus_o[n*2 +: 2]}, {10'b0, w});
      chk($sformatf("R4 bus after ch%0d", n), ctrl_bus_o, exp_ctrl);
    end
  endtask

  task automatic t_invalid;
    logic [2:0]  s0;
    logic [11:0] c0;
    sel_i = 3'd2;
    stat_bus_i = 18'b000_000_000_110_000_000;
    strobe_to(1'b1);
    s0 = stat_o;
    chk("R2 preload", {9'b0, s0}, 12'h006);
    sel_i = 3'd1;
    ctrl_word_i = 2'b01;
    strobe_to(1'b0);
    c0 = ctrl_bus_o;
    for (int k = 6; k < 8; k++) begin
      sel_i = 3'(k);
      stat_bus_i = 18'h3ffff;
      ctrl_word_i = 2'b10;
      strobe_to(1'b1);
      chk($sformatf("R5 sel%0d", k), {9'b0, stat_o}, {9'b0, s0});
      strobe_to(1'b0);
      chk($sformatf("R6 sel%0d", k), ctrl_bus_o, c0);
    end
  endtask

  task automatic t_hold;
    sel_i = 3'd4;
    stat_bus_i = 18'b000_101_000_000_000_000;
    strobe_to(1'b1);
    chk("R2 ch4", {9'b0, stat_o}, 12'h005);
    stat_bus_i = 18'b000_010_000_000_000_000;
    repeat (6) @(negedge clk_i);
    chk("R7 high steady", {9'b0, stat_o}, 12'h005);
    ctrl_word_i = 2'b11;
    strobe_to(1'b0);
    chk("R7 after fall", {9'b0, stat_o}, 12'h005);
    chk("R3 ch4 during hold", ctrl_bus_o, exp_ctrl);
  endtask

  task automatic t_latency;
    sel_i = 3'd0;
    stat_bus_i = 18'b000_000_000_000_000_011;
    @(negedge clk_i);
    strobe_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R8 rise early", {9'b0, stat_o}, 12'h005);
    @(negedge clk_i);
    chk("R8 rise on time", {9'b0, stat_o}, 12'h003);
    ctrl_word_i = 2'b10;
    exp_ctrl[1:0] = 2'b10;
    @(negedge clk_i);
    strobe_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R8 fall early", {10'b0, ctrl_bus_o[1:0]}, 12'h000);
    @(negedge clk_i);
    chk("R8 fall on time", ctrl_bus_o, exp_ctrl);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset;
    t_read;
    t_write;
    t_invalid;
    t_hold;
    exp_ctrl[1:0] = 2'b00;
    sel_i = 3'd0; ctrl_word_i = 2'b00;
    strobe_to(1'b1);
    strobe_to(1'b0);
    sel_i = 3'd4; stat_bus_i = 18'b000_101_000_000_000_000;
    strobe_to(1'b1);
    strobe_to(1'b0);
    exp_ctrl[9:8] = ctrl_word_i;
    t_latency;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule